// File: doc/BRIEF.md
# Port Time-of-Day Timer

This block is a single precision time counter serving one transmit or receive clock domain of a network port. It holds a 48-bit seconds count, a 30-bit nanoseconds count that rolls over at one billion, and a 48-bit fractional nanoseconds accumulator. On every clock edge the whole time value advances by a programmable clock period. The period is expressed in units of 2^-48 ns, so non-integer periods such as 3.2 ns accumulate without long-term drift.

Software reaches the timer through a small 32-bit register bus. Through it, software sets the period and applies a coarse signed step in seconds and nanoseconds. The step takes effect only when the nanoseconds part is written. Software also sets a fine signed offset in 2^-16 ns, which shifts only the time-of-day outputs. Reading the low seconds word freezes a copy of the time, so the remaining words can then be read as one coherent value.

Top module: `port_tod_timer`

## Requirements
- R1: The period is a 56-bit value in 2^-48 ns units. Word 0 holds bits 31:0 and word 1 bits 23:0 holds bits 55:32. Each clock edge adds the period to the time. A period of word1=0x0004_0000, word0=0 advances exactly 4 ns per clock. The 3.2 ns encoding word0=0x3333_3333, word1=0x0003_3333 advances 3199 or 3200 ns over 1000 clocks.
- R2: The nanoseconds count stays below 1,000,000,000. Crossing that value, whether by ticking or by a step, adds one to the seconds count.
- R3: A step is built from three parts. The seconds magnitude is word 3 (bits 31:0) plus word 4 bits 14:0 (bits 46:32). Word 4 bit 15 is the direction flag (1 means subtract). The nanoseconds magnitude is word 5 bits 29:0. A write to word 5 commits the step, and the result appears on the second clock edge after the write. A step that adds carries into the seconds count.
- R4: A step that subtracts borrows from the seconds count when the nanoseconds count would go below zero.
- R5: Writes to words 3 and 4 without a write to word 5 leave the time unchanged.
- R6: Word 2 is a signed fine offset in 2^-16 ns. It is added to the outputs todSec/todNs/todSubNs, with carry or borrow across the second boundary. The running counter is unchanged: the snapshot words still return the unshifted time.
- R7: A read of word 6 returns live seconds bits 31:0 and latches the time at that instant. Later reads of word 7 (seconds bits 47:32) and word 8 (nanoseconds) return the latched values.
- R8: A write is accepted in one cycle. busRvalid is high exactly one cycle after an accepted read, with busRdata valid; a writable word reads back what was written.
- R9: Reserved bits read as zero and ignore writes: word 1 bits 31:24, word 4 bits 31:16, word 5 bits 31:30, word 7 bits 31:16 and word 8 bits 31:30. Addresses 9 to 15 read as zero.
- R10: Reset clears the time, the period and both offsets. With the period at zero the time holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; the timer ticks on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Bus request strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after the read |
| todSec | output | 48 | Time-of-day seconds, fine offset applied |
| todNs | output | 30 | Time-of-day nanoseconds, fine offset applied |
| todSubNs | output | 16 | Time-of-day fraction of a nanosecond in 2^-16 ns |

## Verification
The bench builds the block with its default widths: 48-bit seconds, 30-bit nanoseconds and a 48-bit fraction. Because the step registers can place the time anywhere, the second boundary is reached within a few clocks, without waiting a simulated second. Periods of 4 ns and 3.2 ns are used: the first gives an exact integer advance, and the second brings the fractional carry path into play.

// File: rtl/tod_timer_pkg.sv
package tod_timer_pkg;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 32;
  localparam int SEC_W       = 48;
  localparam int NS_W        = 30;
  localparam int FRAC_W      = 48;
  localparam int PER_INT_W   = 8;
  localparam int PER_W       = FRAC_W + PER_INT_W;
  localparam int FINE_W      = 32;
  localparam int FINE_FRAC_W = 16;
  localparam int NS_PER_SEC  = 1000000000;

  localparam logic [ADDR_W-1:0] REG_PERIOD_LO   = 4'd0;
  localparam logic [ADDR_W-1:0] REG_PERIOD_HI   = 4'd1;
  localparam logic [ADDR_W-1:0] REG_FINE_OFS    = 4'd2;
  localparam logic [ADDR_W-1:0] REG_STEP_SEC_LO = 4'd3;
  localparam logic [ADDR_W-1:0] REG_STEP_SEC_HI = 4'd4;
  localparam logic [ADDR_W-1:0] REG_STEP_NS     = 4'd5;
  localparam logic [ADDR_W-1:0] REG_SNAP_SEC_LO = 4'd6;
  localparam logic [ADDR_W-1:0] REG_SNAP_SEC_HI = 4'd7;
  localparam logic [ADDR_W-1:0] REG_SNAP_NS     = 4'd8;

  typedef struct packed {
    logic stepCommit;
    logic snapTake;
  } timerStrobes_t;
endpackage

// File: rtl/tod_timer_ctrl.sv
module tod_timer_ctrl
  import tod_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busRvalid,
  input  logic [31:0]          liveSecLo,
  input  logic [SEC_W-33:0]    snapSecHi,
  input  logic [NS_W-1:0]      snapNs,
  output timerStrobes_t        strobes,
  output logic [PER_W-1:0]     periodVal,
  output logic [FINE_W-1:0]    fineOfs,
  output logic                 stepSub,
  output logic [SEC_W-2:0]     stepMag,
  output logic [NS_W-1:0]      stepNs
);
  localparam int HI_W = PER_W - 32;
  localparam int SH_W = SEC_W - 32;

  logic [31:0]     periodLo, stepSecLo;
  logic [HI_W-1:0] periodHi;
  logic [SH_W-1:0] stepSecHi;
  logic            commitQ;
  logic            wrEn, rdEn;

  assign wrEn = busValid && busWrite;
  assign rdEn = busValid && !busWrite;

  assign strobes.stepCommit = commitQ;
  assign strobes.snapTake   = rdEn && (busAddr == REG_SNAP_SEC_LO);

  assign periodVal = {periodHi, periodLo};
  assign stepSub   = stepSecHi[SH_W-1];
  assign stepMag   = {stepSecHi[SH_W-2:0], stepSecLo};

  always_ff @(posedge clk) begin
    if (rst) begin
      periodLo  <= '0;
      periodHi  <= '0;
      fineOfs   <= '0;
      stepSecLo <= '0;
      stepSecHi <= '0;
      stepNs    <= '0;
      commitQ   <= 1'b0;
    end else begin
      commitQ <= wrEn && (busAddr == REG_STEP_NS);
      if (wrEn) begin
        case (busAddr)
          REG_PERIOD_LO:   periodLo  <= busWdata;
          REG_PERIOD_HI:   periodHi  <= busWdata[HI_W-1:0];
          REG_FINE_OFS:    fineOfs   <= busWdata;
          REG_STEP_SEC_LO: stepSecLo <= busWdata;
          REG_STEP_SEC_HI: stepSecHi <= busWdata[SH_W-1:0];
          REG_STEP_NS:     stepNs    <= busWdata[NS_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
    end else begin
      busRvalid <= rdEn;
      if (rdEn) begin
        case (busAddr)
          REG_PERIOD_LO:   busRdata <= periodLo;
          REG_PERIOD_HI:   busRdata <= {{(DATA_W-HI_W){1'b0}}, periodHi};
          REG_FINE_OFS:    busRdata <= fineOfs;
          REG_STEP_SEC_LO: busRdata <= stepSecLo;
          REG_STEP_SEC_HI: busRdata <= {{(DATA_W-SH_W){1'b0}}, stepSecHi};
          REG_STEP_NS:     busRdata <= {{(DATA_W-NS_W){1'b0}}, stepNs};
          REG_SNAP_SEC_LO: busRdata <= liveSecLo;
          REG_SNAP_SEC_HI: busRdata <= {{(DATA_W-SH_W){1'b0}}, snapSecHi};
          REG_SNAP_NS:     busRdata <= {{(DATA_W-NS_W){1'b0}}, snapNs};
          default:         busRdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tod_timer_dp.sv
module tod_timer_dp
  import tod_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  timerStrobes_t        strobes,
  input  logic [PER_W-1:0]     periodVal,
  input  logic [FINE_W-1:0]    fineOfs,
  input  logic                 stepSub,
  input  logic [SEC_W-2:0]     stepMag,
  input  logic [NS_W-1:0]      stepNs,
  output logic [SEC_W-1:0]     rawSec,
  output logic [NS_W-1:0]      rawNs,
  output logic [SEC_W-33:0]    snapSecHi,
  output logic [NS_W-1:0]      snapNs,
  output logic [SEC_W-1:0]     todSec,
  output logic [NS_W-1:0]      todNs,
  output logic [FINE_FRAC_W-1:0] todSubNs
);
  localparam int SUM_W = NS_W + 3;
  localparam int FSW   = NS_W + FINE_FRAC_W + 2;
  localparam int FAW   = NS_W + FINE_FRAC_W;
  localparam logic signed [SUM_W-1:0] ONE_SEC  = SUM_W'(NS_PER_SEC);
  localparam logic signed [SUM_W-1:0] TWO_SEC  = ONE_SEC + ONE_SEC;
  localparam logic signed [FSW-1:0]   SEC_UNITS = FSW'(NS_PER_SEC) <<< FINE_FRAC_W;

  logic [FRAC_W-1:0]      fracQ;
  logic [FRAC_W:0]        fracSum;
  logic [PER_INT_W:0]     nsInc;
  logic signed [SUM_W-1:0] nsBase, nsOfsS, nsSum;
  logic [NS_W-1:0]        nsNext;
  logic [SEC_W-1:0]       secAdj, secStep, stepMagExt, secNext;

  // tick: fractional accumulate, carry into integer nanoseconds
  assign fracSum = {1'b0, fracQ} + {1'b0, periodVal[FRAC_W-1:0]};
  assign nsInc   = {1'b0, periodVal[PER_W-1:FRAC_W]} + {{PER_INT_W{1'b0}}, fracSum[FRAC_W]};
  assign nsBase  = $signed({3'b000, rawNs}) + $signed({{(SUM_W-PER_INT_W-1){1'b0}}, nsInc});
  assign nsOfsS  = $signed({3'b000, stepNs});

  // tick and committed step share one adder chain
  always_comb begin
    if (!strobes.stepCommit) nsSum = nsBase;
    else if (stepSub)        nsSum = nsBase - nsOfsS;
    else                     nsSum = nsBase + nsOfsS;

    if (nsSum < 0) begin
      nsNext = NS_W'(nsSum + ONE_SEC);
      secAdj = '1;
    end else if (nsSum >= TWO_SEC) begin
      nsNext = NS_W'(nsSum - TWO_SEC);
      secAdj = SEC_W'(2);
    end else if (nsSum >= ONE_SEC) begin
      nsNext = NS_W'(nsSum - ONE_SEC);
      secAdj = SEC_W'(1);
    end else begin
      nsNext = NS_W'(nsSum);
      secAdj = '0;
    end
  end

  assign stepMagExt = {1'b0, stepMag};
  assign secStep = !strobes.stepCommit ? '0 : (stepSub ? -stepMagExt : stepMagExt);
  assign secNext = rawSec + secStep + secAdj;

  always_ff @(posedge clk) begin
    if (rst) begin
      fracQ     <= '0;
      rawNs     <= '0;
      rawSec    <= '0;
      snapSecHi <= '0;
      snapNs    <= '0;
    end else begin
      fracQ  <= fracSum[FRAC_W-1:0];
      rawNs  <= nsNext;
      rawSec <= secNext;
      if (strobes.snapTake) begin
        snapSecHi <= rawSec[SEC_W-1:32];
        snapNs    <= rawNs;
      end
    end
  end

  // fine output offset, applied on the output path only
  logic signed [FSW-1:0] fineBase, fineExt, fineSum;
  logic [FAW-1:0]        fineAdj;

  assign fineBase = $signed({2'b00, rawNs, fracQ[FRAC_W-1 -: FINE_FRAC_W]});
  assign fineExt  = $signed({{(FSW-FINE_W){fineOfs[FINE_W-1]}}, fineOfs});
  assign fineSum  = fineBase + fineExt;

  always_comb begin
    if (fineSum < 0) begin
      fineAdj = FAW'(fineSum + SEC_UNITS);
      todSec  = rawSec - SEC_W'(1);
    end else if (fineSum >= SEC_UNITS) begin
      fineAdj = FAW'(fineSum - SEC_UNITS);
      todSec  = rawSec + SEC_W'(1);
    end else begin
      fineAdj = FAW'(fineSum);
      todSec  = rawSec;
    end
  end

  assign todNs    = fineAdj[FAW-1:FINE_FRAC_W];
  assign todSubNs = fineAdj[FINE_FRAC_W-1:0];
endmodule

// File: rtl/port_tod_timer.sv
module port_tod_timer
  import tod_timer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic                   busRvalid,
  output logic [SEC_W-1:0]       todSec,
  output logic [NS_W-1:0]        todNs,
  output logic [FINE_FRAC_W-1:0] todSubNs
);
  timerStrobes_t       strobes;
  logic [PER_W-1:0]    periodVal;
  logic [FINE_W-1:0]   fineOfs;
  logic                stepSub;
  logic [SEC_W-2:0]    stepMag;
  logic [NS_W-1:0]     stepNs;
  logic [SEC_W-1:0]    rawSec;
  logic [NS_W-1:0]     rawNs;
  logic [SEC_W-33:0]   snapSecHi;
  logic [NS_W-1:0]     snapNs;

  tod_timer_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid),
    .liveSecLo(rawSec[31:0]), .snapSecHi(snapSecHi), .snapNs(snapNs),
    .strobes(strobes), .periodVal(periodVal), .fineOfs(fineOfs),
    .stepSub(stepSub), .stepMag(stepMag), .stepNs(stepNs)
  );

  tod_timer_dp u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .periodVal(periodVal), .fineOfs(fineOfs),
    .stepSub(stepSub), .stepMag(stepMag), .stepNs(stepNs),
    .rawSec(rawSec), .rawNs(rawNs), .snapSecHi(snapSecHi), .snapNs(snapNs),
    .todSec(todSec), .todNs(todNs), .todSubNs(todSubNs)
  );
endmodule

// File: rtl/tod_timer_chk.sv
module tod_timer_chk
  import tod_timer_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busRdata,
  input logic               busRvalid,
  input logic [SEC_W-1:0]   todSec,
  input logic [NS_W-1:0]    todNs,
  input logic [SEC_W-1:0]   rawSec,
  input logic [NS_W-1:0]    rawNs,
  input logic [PER_W-1:0]   periodVal,
  input logic [FINE_W-1:0]  fineOfs,
  input logic               stepCommit
);
  // R2: both counters stay below one second
  a_r2_ns_range: assert property (@(posedge clk) disable iff (rst)
    (rawNs < NS_W'(NS_PER_SEC)) && (todNs < NS_W'(NS_PER_SEC)));

  // R10 and R5: zero period and no committed step leave the time unchanged
  a_r10_hold_zero_period: assert property (@(posedge clk) disable iff (rst)
    (periodVal == '0 && !stepCommit) |=> ($stable(rawNs) && $stable(rawSec)));

  // R8: read data valid exactly one cycle after an accepted read
  a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite) |=> busRvalid);
  a_r8_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
    !(busValid && !busWrite) |=> !busRvalid);

  // R9: reserved bits of the snapshot words read as zero
  a_r9_snap_ns_resv: assert property (@(posedge clk) disable iff (rst)
    (busRvalid && $past(busAddr) == REG_SNAP_NS) |-> (busRdata[31:30] == 2'b00));
  a_r9_snap_sec_resv: assert property (@(posedge clk) disable iff (rst)
    (busRvalid && $past(busAddr) == REG_SNAP_SEC_HI) |-> (busRdata[31:16] == 16'h0));

  // R6: with no fine offset the output equals the running counter
  a_r6_zero_fine_passthru: assert property (@(posedge clk) disable iff (rst)
    (fineOfs == '0) |-> (todNs == rawNs && todSec == rawSec));
endmodule

bind port_tod_timer tod_timer_chk u_chk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busRdata(busRdata), .busRvalid(busRvalid), .todSec(todSec), .todNs(todNs),
  .rawSec(rawSec), .rawNs(rawNs), .periodVal(periodVal), .fineOfs(fineOfs),
  .stepCommit(strobes.stepCommit)
);

// File: tb/tb_port_tod_timer.sv
`timescale 1ns/1ps
module tb_port_tod_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [47:0] todSec;
  logic [29:0] todNs;
  logic [15:0] todSubNs;

  int checks = 0, errors = 0;
  int cycles = 0;

  port_tod_timer dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d, output logic rv,
                       output logic [47:0] capSec, output logic [29:0] capNs);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    capSec = todSec; capNs = todNs;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata; rv = busRvalid;
  endtask

  task automatic stepTime(input bit sub, input logic [46:0] mag, input logic [29:0] ns);
    busWr(4'd3, mag[31:0]);
    busWr(4'd4, {16'h0, sub, mag[46:32]});
    busWr(4'd5, {2'b00, ns});
    @(negedge clk);
  endtask

  function automatic logic [63:0] totalNs();
    return 64'(todSec) * 64'd1000000000 + 64'(todNs);
  endfunction

  task automatic tReset();
    logic [31:0] d; logic rv; logic [47:0] cs; logic [29:0] cn;
    chk(todSec == 0 && todNs == 0 && todSubNs == 0, "R10 reset time", totalNs(), 0);
    busRd(4'd0, d, rv, cs, cn);
    chk(d == 0, "R10 reset period", d, 0);
  endtask

  task automatic tStepAdd();
    stepTime(1'b0, 47'd5, 30'd100);
    chk(todSec == 5 && todNs == 100, "R3 add step", totalNs(), 64'd5000000100);
    stepTime(1'b0, 47'd0, 30'd999999950);
    chk(todSec == 6 && todNs == 50, "R2 R3 add step carry", totalNs(), 64'd6000000050);
  endtask

  task automatic tStepSub();
    stepTime(1'b1, 47'd0, 30'd60);
    chk(todSec == 5 && todNs == 999999990, "R4 sub step borrow", totalNs(), 64'd5999999990);
    stepTime(1'b1, 47'd2, 30'd0);
    chk(todSec == 3 && todNs == 999999990, "R4 sub seconds", totalNs(), 64'd3999999990);
  endtask

  task automatic tNoCommit();
    logic [31:0] d; logic rv; logic [47:0] cs; logic [29:0] cn;
    busWr(4'd3, 32'd77);
    busWr(4'd4, 32'h0000_8000);
    repeat (3) @(negedge clk);
    chk(todSec == 3 && todNs == 999999990, "R5 R10 seconds words alone", totalNs(), 64'd3999999990);
    busRd(4'd3, d, rv, cs, cn);
    chk(d == 77 && rv, "R8 readback step seconds", d, 77);
  endtask

  task automatic tFine();
    logic [31:0] d; logic rv; logic [47:0] cs; logic [29:0] cn;
    busWr(4'd2, 32'h0014_0000);
    @(negedge clk);
    chk(todSec == 4 && todNs == 10 && todSubNs == 0, "R6 fine offset carry", totalNs(), 64'd4000000010);
    busRd(4'd6, d, rv, cs, cn);
    chk(d == 3, "R6 R7 raw seconds low", d, 3);
    busRd(4'd8, d, rv, cs, cn);
    chk(d == 999999990, "R6 R7 raw ns snapshot", d, 999999990);
    busRd(4'd7, d, rv, cs, cn);
    chk(d == 0, "R7 seconds high snapshot", d, 0);
    busWr(4'd2, 32'h0);
    stepTime(1'b0, 47'd0, 30'd10);
    chk(todSec == 4 && todNs == 0, "R2 step to boundary", totalNs(), 64'd4000000000);
    busWr(4'd2, 32'hFFFF_8000);
    @(negedge clk);
    chk(todSec == 3 && todNs == 999999999 && todSubNs == 16'h8000, "R6 fine offset borrow",
        {todNs, todSubNs}, {30'd999999999, 16'h8000});
    busWr(4'd2, 32'h0);
  endtask

  task automatic tPeriod();
    logic [31:0] d; logic rv; logic [47:0] cs; logic [29:0] cn;
    logic [63:0] t0, t1;
    busWr(4'd1, 32'h0004_0000);
    @(negedge clk);
    t0 = totalNs();
    repeat (10) @(negedge clk);
    t1 = totalNs();
    chk(t1 - t0 == 40, "R1 4ns period", t1 - t0, 40);
    busWr(4'd0, 32'h3333_3333);
    busWr(4'd1, 32'h0003_3333);
    busRd(4'd0, d, rv, cs, cn);
    chk(d == 32'h3333_3333, "R1 period low readback", d, 32'h3333_3333);
    t0 = totalNs();
    repeat (1000) @(negedge clk);
    t1 = totalNs();
    chk(t1 - t0 == 3200 || t1 - t0 == 3199, "R1 3.2ns period", t1 - t0, 3200);
  endtask

  task automatic tSnapRunning();
    logic [31:0] d; logic rv; logic [47:0] cs; logic [29:0] cn;
    logic [47:0] s0; logic [29:0] n0;
    busRd(4'd6, d, rv, s0, n0);
    chk(d == s0[31:0], "R7 live seconds low", d, s0[31:0]);
    repeat (5) @(negedge clk);
    busRd(4'd8, d, rv, cs, cn);
    chk(d == {2'b00, n0} && cn != n0, "R7 latched ns", d, n0);
    busRd(4'd7, d, rv, cs, cn);
    chk(d == {16'h0, s0[47:32]} && rv, "R7 latched seconds high", d, s0[47:32]);
    @(negedge clk);
    chk(!busRvalid, "R8 rvalid single cycle", busRvalid, 0);
  endtask

  task automatic tWrapRunning();
    logic [47:0] s;
    busWr(4'd0, 32'h0);
    busWr(4'd1, 32'h0);
    @(negedge clk);
    s = todSec;
    stepTime(1'b1, 47'd0, todNs);
    stepTime(1'b0, 47'd0, 30'd999999980);
    chk(todSec == s && todNs == 999999980, "R10 R3 set near wrap", todNs, 999999980);
    busWr(4'd1, 32'h0004_0000);
    repeat (10) @(negedge clk);
    chk(todSec == s + 1 && todNs == 20, "R2 running wrap", todNs, 20);
    busWr(4'd1, 32'h0);
  endtask

  task automatic tReserved();
    logic [31:0] d; logic rv; logic [47:0] cs; logic [29:0] cn;
    busWr(4'd1, 32'hFFFF_FFFF);
    busWr(4'd1, 32'h0);
    busWr(4'd4, 32'hFFFF_FFFF);
    busRd(4'd4, d, rv, cs, cn);
    chk(d == 32'h0000_FFFF, "R9 step seconds high reserved", d, 32'h0000_FFFF);
    busWr(4'd4, 32'h0);
    busRd(4'd1, d, rv, cs, cn);
    chk(d == 0, "R9 period high after clear", d, 0);
    busRd(4'd12, d, rv, cs, cn);
    chk(d == 0 && rv, "R9 unmapped address", d, 0);
    busWr(4'd1, 32'hFF12_3456);
    busRd(4'd1, d, rv, cs, cn);
    chk(d == 32'h0012_3456, "R9 period high reserved", d, 32'h0012_3456);
    busWr(4'd1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tStepAdd();
    tStepSub();
    tNoCommit();
    tFine();
    tPeriod();
    tSnapRunning();
    tWrapRunning();
    tReserved();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule